// File: doc/BRIEF.md
# Latency-Hiding Thread Scheduler

This block decides, every clock cycle, which resident hardware thread may issue its next instruction on a single shared execution engine. It holds a small record per thread slot: a valid flag, a ready flag, a program counter and a context tag. The context tag lets one slot pool carry several kinds of work, such as different pipeline task types and data-parallel work elements. The scheduler picks among ready slots in round-robin order, so long memory latency is hidden by switching to other resident threads rather than by a cache.

The engine answers in the same cycle as each issue. It reports whether the issued instruction makes a memory reference or depends on one, in which case the thread goes to sleep. It also reports whether the thread has finished, and whether the next PC is a branch target instead of the next sequential address. The memory system wakes a sleeping thread by returning its slot number. New threads enter through a launch port that gives a start PC and a context tag. When no slot can run, the block raises a stall.

Top module: `thread_sched`

## Requirements
- R1: After reset no slot is occupied: `stall` is 1, `issue_valid` is 0, `launch_ready` is 1 and `launch_tid` is 0.
- R2: A launch is taken when `launch_valid` and `launch_ready` are both 1. It fills the lowest-numbered free slot, and `launch_tid` shows that slot number beforehand. From the next cycle the slot is occupied and ready, with the given PC and context. `launch_ready` is 0 exactly when all NUM_SLOTS slots are occupied.
- R3: When any occupied slot is ready, `issue_valid` is 1. `issue_tid` is then the first such slot found by searching upward from one past the last issued slot, wrapping from NUM_SLOTS-1 to 0. Until the first issue the last issued slot counts as NUM_SLOTS-1. `issue_pc` and `issue_ctx` are that slot's stored values, and the context tag never changes while the thread lives.
- R4: `stall` is 1 exactly when no occupied slot is ready, and it is always the inverse of `issue_valid`.
- R5: An issued thread that does not retire gets its stored PC advanced to `issue_pc`+1, modulo 2^PC_W. When `issue_jump` is 1 it gets `issue_target` instead.
- R6: When `issue_block` is 1 with an issue, the issued thread is not ready from the next cycle on. It is then skipped by selection until it is woken.
- R7: `ret_valid` with slot `ret_tid` makes that slot ready from the next cycle if it is occupied. A return to a free slot or to a slot that is already ready changes nothing.
- R8: A return for the slot that is blocking itself in the same cycle leaves that thread ready in the next cycle.
- R9: When `issue_retire` is 1 with an issue, the issued slot becomes free in the next cycle, even if `issue_block` is also 1. Once free, the slot can be launched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Request to start a new thread |
| launch_pc | input | PC_W | Start PC of the new thread |
| launch_ctx | input | CTX_W | Context tag of the new thread |
| launch_ready | output | 1 | A free slot exists |
| launch_tid | output | TID_W | Slot a launch this cycle would fill |
| issue_valid | output | 1 | A thread issues this cycle |
| issue_tid | output | TID_W | Slot of the issuing thread |
| issue_pc | output | PC_W | PC of the issuing thread |
| issue_ctx | output | CTX_W | Context tag of the issuing thread |
| stall | output | 1 | No thread can issue this cycle |
| issue_block | input | 1 | Issued instruction waits on memory |
| issue_retire | input | 1 | Issued thread ends |
| issue_jump | input | 1 | Use issue_target as the next PC |
| issue_target | input | PC_W | Branch target for the issued thread |
| ret_valid | input | 1 | Memory data returned for a thread |
| ret_tid | input | TID_W | Slot the returned data belongs to |

## Verification
A wake from the memory side and a block from the issue side can hit the same slot in one cycle. The bench provokes this by choosing the return slot equal to the slot the reference model expects to issue, and by setting `issue_block` in that same cycle. Whether the thread won is judged later, from the selection order and the stall output: a thread that stayed ready shows up again in its round-robin turn. A retire that lands in the same cycle as a return for the same slot is also driven, in the random phase. The freed slot must then not come back to life.

// File: rtl/thread_sched_pkg.sv
package thread_sched_pkg;

    parameter int TS_SLOTS_DEF = 16;
    parameter int TS_PC_W_DEF  = 16;
    parameter int TS_CTX_W_DEF = 4;

    // Width of a slot index for a given slot count.
    function automatic int tid_width(input int slots);
        return (slots > 1) ? $clog2(slots) : 1;
    endfunction

endpackage

// File: rtl/ts_free_find.sv
module ts_free_find #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     occupied,
    output logic             any_free,
    output logic [IDX_W-1:0] free_idx
);

    logic [N-1:0] free_v;
    logic [N:0]   seen;
    logic [N-1:0] first_oh;

    assign free_v  = ~occupied;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign first_oh[i] = free_v[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | free_v[i];
    end

    assign any_free = seen[N];

    always_comb begin
        free_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first_oh[i]) free_idx = free_idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/ts_rr_pick.sv
module ts_rr_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx,
    output logic [N-1:0]     gnt_oh
);

    // Search order starts one slot past the last grant and wraps.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        gnt_oh    = '0;
        for (int off = 1; off <= N; off++) begin
            int cand;
            cand = int'(last) + off;
            if (cand >= N) cand = cand - N;
            if (!gnt_valid && req[cand]) begin
                gnt_valid    = 1'b1;
                gnt_idx      = IDX_W'(cand);
                gnt_oh[cand] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/thread_sched.sv
module thread_sched
    import thread_sched_pkg::*;
#(
    parameter int NUM_SLOTS = TS_SLOTS_DEF,
    parameter int PC_W      = TS_PC_W_DEF,
    parameter int CTX_W     = TS_CTX_W_DEF,
    localparam int TID_W    = tid_width(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_valid,
    input  logic [PC_W-1:0]  launch_pc,
    input  logic [CTX_W-1:0] launch_ctx,
    output logic             launch_ready,
    output logic [TID_W-1:0] launch_tid,
    output logic             issue_valid,
    output logic [TID_W-1:0] issue_tid,
    output logic [PC_W-1:0]  issue_pc,
    output logic [CTX_W-1:0] issue_ctx,
    output logic             stall,
    input  logic             issue_block,
    input  logic             issue_retire,
    input  logic             issue_jump,
    input  logic [PC_W-1:0]  issue_target,
    input  logic             ret_valid,
    input  logic [TID_W-1:0] ret_tid
);

    localparam logic [TID_W-1:0] LAST_INIT = TID_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic [NUM_SLOTS-1:0]            valid;
        logic [NUM_SLOTS-1:0]            ready;
        logic [NUM_SLOTS-1:0][PC_W-1:0]  pc;
        logic [NUM_SLOTS-1:0][CTX_W-1:0] ctx;
        logic [TID_W-1:0]                last;
    } sched_st_t;

    sched_st_t st_d, st_q;

    logic [NUM_SLOTS-1:0] runnable;
    logic [NUM_SLOTS-1:0] pick_oh;
    logic                 ret_in_range;
    logic                 same_slot_wake;

    assign runnable = st_q.valid & st_q.ready;

    ts_rr_pick #(.N(NUM_SLOTS), .IDX_W(TID_W)) u_pick (
        .req       (runnable),
        .last      (st_q.last),
        .gnt_valid (issue_valid),
        .gnt_idx   (issue_tid),
        .gnt_oh    (pick_oh)
    );

    ts_free_find #(.N(NUM_SLOTS), .IDX_W(TID_W)) u_free (
        .occupied (st_q.valid),
        .any_free (launch_ready),
        .free_idx (launch_tid)
    );

    assign issue_pc  = st_q.pc[issue_tid];
    assign issue_ctx = st_q.ctx[issue_tid];
    assign stall     = ~issue_valid;

    assign ret_in_range   = (int'(ret_tid) < NUM_SLOTS);
    assign same_slot_wake = ret_valid && (ret_tid == issue_tid);

    always_comb begin
        st_d = st_q;

        // Memory return wakes an occupied slot.
        if (ret_valid && ret_in_range && st_q.valid[ret_tid]) begin
            st_d.ready[ret_tid] = 1'b1;
        end

        // Feedback for the thread issued this cycle.
        if (issue_valid) begin
            st_d.last = issue_tid;
            if (issue_retire) begin
                st_d.valid[issue_tid] = 1'b0;
                st_d.ready[issue_tid] = 1'b0;
            end else begin
                st_d.pc[issue_tid] = issue_jump ? issue_target
                                                : issue_pc + PC_W'(1);
                if (issue_block && !same_slot_wake) begin
                    st_d.ready[issue_tid] = 1'b0;
                end
            end
        end

        // Launch into the lowest free slot (never the issuing slot).
        if (launch_valid && launch_ready) begin
            st_d.valid[launch_tid] = 1'b1;
            st_d.ready[launch_tid] = 1'b1;
            st_d.pc[launch_tid]    = launch_pc;
            st_d.ctx[launch_tid]   = launch_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.ready <= '0;
            st_q.pc    <= '0;
            st_q.ctx   <= '0;
            st_q.last  <= LAST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_oh) && (issue_valid == (pick_oh != '0))); // R3

    AST_GRANT_RUNNABLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (st_q.valid[issue_tid] && st_q.ready[issue_tid])); // R3

    AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (runnable == '0)); // R4

    AST_LAUNCH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_valid && launch_ready) |=>
            (st_q.valid[$past(launch_tid)] && st_q.ready[$past(launch_tid)])); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !issue_retire && !issue_jump) |=>
            (st_q.pc[$past(issue_tid)] == $past(issue_pc) + PC_W'(1))); // R5

    AST_BLOCK_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_block && !issue_retire && !same_slot_wake) |=>
            !st_q.ready[$past(issue_tid)]); // R6

    AST_WAKE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_in_range && st_q.valid[ret_tid] &&
         !(issue_valid && issue_retire && issue_tid == ret_tid)) |=>
            st_q.ready[$past(ret_tid)]); // R8

    AST_RETIRE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_retire) |=> !st_q.valid[$past(issue_tid)]); // R9

endmodule

// File: tb/thread_sched_bench.sv
module thread_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int PC_W  = 16;
    localparam int CTX_W = 4;
    localparam int TID_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             launch_valid = 1'b0;
    logic [PC_W-1:0]  launch_pc = '0;
    logic [CTX_W-1:0] launch_ctx = '0;
    logic             launch_ready;
    logic [TID_W-1:0] launch_tid;
    logic             issue_valid;
    logic [TID_W-1:0] issue_tid;
    logic [PC_W-1:0]  issue_pc;
    logic [CTX_W-1:0] issue_ctx;
    logic             stall;
    logic             issue_block = 1'b0;
    logic             issue_retire = 1'b0;
    logic             issue_jump = 1'b0;
    logic [PC_W-1:0]  issue_target = '0;
    logic             ret_valid = 1'b0;
    logic [TID_W-1:0] ret_tid = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thread_sched #(.NUM_SLOTS(N), .PC_W(PC_W), .CTX_W(CTX_W)) u_thread_sched (
        .clk, .rst_n, .launch_valid, .launch_pc, .launch_ctx, .launch_ready,
        .launch_tid, .issue_valid, .issue_tid, .issue_pc, .issue_ctx, .stall,
        .issue_block, .issue_retire, .issue_jump, .issue_target, .ret_valid,
        .ret_tid
    );

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    // Reference model: plain arrays and a last-issued index.
    bit m_valid [N];
    bit m_ready [N];
    int m_pc    [N];
    int m_ctx   [N];
    int m_last  = N - 1;

    int e_tid;
    int e_free;
    int order_q [$];

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    function automatic void model_expect();
        e_tid = -1;
        for (int off = 1; off <= N; off++) begin
            int c;
            c = (m_last + off) % N;
            if (e_tid < 0 && m_valid[c] && m_ready[c]) e_tid = c;
        end
        e_free = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) e_free = i;
    endfunction

    // One cycle: check outputs at the falling edge, drive, update the model.
    task automatic cyc(input bit lv, input int lpc, input int lctx,
                       input bit blk, input bit ret, input bit jmp, input int tgt,
                       input bit rv, input int rtid);
        model_expect();
        check("R4 stall", int'(stall), (e_tid < 0) ? 1 : 0);
        check("R3 issue_valid", int'(issue_valid), (e_tid < 0) ? 0 : 1);
        if (e_tid >= 0) begin
            check("R3 issue_tid", int'(issue_tid), e_tid);
            check("R5 issue_pc", int'(issue_pc), m_pc[e_tid]);
            check("R3 issue_ctx", int'(issue_ctx), m_ctx[e_tid]);
            order_q.push_back(e_tid);
        end
        check("R2 launch_ready", int'(launch_ready), (e_free < 0) ? 0 : 1);
        if (e_free >= 0) check("R2 launch_tid", int'(launch_tid), e_free);

        launch_valid = lv;
        launch_pc    = PC_W'(lpc);
        launch_ctx   = CTX_W'(lctx);
        issue_block  = blk;
        issue_retire = ret;
        issue_jump   = jmp;
        issue_target = PC_W'(tgt);
        ret_valid    = rv;
        ret_tid      = TID_W'(rtid);

        begin
            bit wake_same;
            wake_same = rv && (rtid == e_tid);
            if (rv && m_valid[rtid]) m_ready[rtid] = 1'b1;
            if (e_tid >= 0) begin
                m_last = e_tid;
                if (ret) begin
                    m_valid[e_tid] = 1'b0;
                    m_ready[e_tid] = 1'b0;
                end else begin
                    m_pc[e_tid] = jmp ? tgt : (m_pc[e_tid] + 1) % (1 << PC_W);
                    if (blk && !wake_same) m_ready[e_tid] = 1'b0;
                end
            end
            if (lv && e_free >= 0) begin
                m_valid[e_free] = 1'b1;
                m_ready[e_free] = 1'b1;
                m_pc[e_free]    = lpc;
                m_ctx[e_free]   = lctx;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ready[i] = 0; m_pc[i] = 0; m_ctx[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        phase = "R1";
        check("R1 stall", int'(stall), 1);
        check("R1 issue_valid", int'(issue_valid), 0);
        check("R1 launch_ready", int'(launch_ready), 1);
        check("R1 launch_tid", int'(launch_tid), 0);

        // R2/R3: three launches with two context kinds, round-robin order
        phase = "R2 launch";
        cyc(1, 100, 1, 0, 0, 0, 0, 0, 0);
        cyc(1, 200, 2, 0, 0, 0, 0, 0, 0);
        cyc(1, 300, 1, 0, 0, 0, 0, 0, 0);
        phase = "R3 rotate";
        order_q.delete();
        idle(6);
        check("R3 rotation seen", order_q.size(), 6);

        // R6: block slot 1 while it issues; R7: wake it later
        phase = "R6 block";
        while (e_tid != 1) begin model_expect(); if (e_tid != 1) idle(1); end
        cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
        idle(4);
        phase = "R7 wake";
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 9);   // return to a free slot: no effect
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);   // return to a ready slot: no effect
        idle(4);

        // R8: block and return for the same slot in one cycle
        phase = "R8 same-cycle";
        model_expect();
        cyc(0, 0, 0, 1, 0, 0, 0, 1, e_tid);
        idle(4);

        // R4: block every thread, engine stalls, then one wakes
        phase = "R4 all blocked";
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 1, 0, 0, 0, 0, 0);
        idle(2);
        check("R4 stall held", int'(stall), 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 2);
        idle(3);

        // R5: jump
        phase = "R5 jump";
        cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 1, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
        idle(5);                           // includes PC wrap from FFFF

        // R9: retire while also blocking, then reuse the slot
        phase = "R9 retire";
        cyc(0, 0, 0, 1, 1, 0, 0, 0, 0);
        idle(2);
        cyc(1, 777, 3, 0, 0, 0, 0, 0, 0);
        idle(4);

        // R2: fill every slot, launch_ready drops
        phase = "R2 full";
        for (int k = 0; k < N + 2; k++) cyc(1, 1000 + k, k % 4, 0, 0, 0, 0, 0, 0);
        check("R2 full ready low", int'(launch_ready), 0);
        idle(3);

        // Mixed random traffic, including return and retire on the same slot
        phase = "R8 R9 random";
        for (int k = 0; k < 3000; k++) begin
            int r;
            model_expect();
            r = $urandom_range(0, 99);
            cyc(($urandom_range(0, 3) == 0), $urandom_range(0, 65535),
                $urandom_range(0, 15),
                ($urandom_range(0, 2) == 0), (r < 6),
                ($urandom_range(0, 9) == 0), $urandom_range(0, 65535),
                ($urandom_range(0, 1) == 0),
                ($urandom_range(0, 3) == 0 && e_tid >= 0) ? e_tid
                                                          : $urandom_range(0, N - 1));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule